// File: doc/BRIEF.md
# Cycle-Count Timer Interrupt Mapper

This block sits behind the serial register loader of a cartridge memory mapper. The loader delivers each finished 5-bit value together with its register index. One of the usual pattern-bank registers is given a new job here. It gates and clears a long CPU-cycle timer that raises an interrupt, and it chooses how program ROM is banked. Pattern memory is a fixed 8 KB RAM, so no pattern bank output is needed. The block drives the two 16 KB program bank numbers, for the windows at 0x8000 and 0xC000, and a level interrupt request.

The timer is a finite-state machine with three named states:
- `T_RUN`: counting, interrupt low.
- `T_PEND`: interrupt asserted and still counting.
- `T_HOLD`: counter frozen at zero, interrupt low.

The transitions are:
- `RUN->PEND`: the threshold is reached on an enabled cycle.
- `PEND->PEND`: the threshold is reached again; the counter restarts from zero.
- `RUN/PEND/HOLD->HOLD`: the timer register is written with bit 4 set.
- `HOLD->RUN`: the timer register is written with bit 4 clear.

Top module: `cyc_irq_mapper`

## Requirements
- R1: Reset sets the internal values as follows:
  - mode register (index 0) to 0x1F;
  - timer register (index 1) to 0;
  - program register (index 3) to 0.
  
  This gives bank_lo=0, bank_hi=1 and irq=0. After reset, a single write of 0x08 to index 1 gives bank_lo=8 and bank_hi=15.
- R2: While bit 3 of the timer register is 0, a 32 KB block b = timer register bits 2:1 is mapped. The outputs are bank_lo = 2b and bank_hi = 2b+1, whatever the mode register holds.
- R3: With timer register bit 3 = 1 and mode register bits 3:2 = 11: bank_lo = 8 | (p & 7) and bank_hi = 15, where p is the program register.
- R4: With timer register bit 3 = 1 and mode bits 3:2 = 10: bank_lo = 8 and bank_hi = 8 | (p & 7).
- R5: With timer register bit 3 = 1 and mode bits 3:2 = 0x: bank_lo = 8 | (p & 6) and bank_hi = 8 | (p & 6) | 1.
- R6: The counter advances once per cycle with cpu_cyc_en high, and only then. irq goes high after the Nth enabled cycle. N is the least value for which N OR (DIP_SET << (CNT_W-5)) is at least 31 << (CNT_W-5). DIP_SET defaults to 0xE.
- R7: irq is a level. Once high, it stays high whatever cpu_cyc_en does, until a clearing write. The counter restarts from zero at the moment it fires.
- R8: A write to index 1 with bit 4 set drops irq after that edge and clears the counter. irq stays low, however many enabled cycles pass, while bit 4 remains set.
- R9: A write to index 1 with bit 4 clear leaves hold, and counting restarts from zero. The same write made while irq is high leaves irq high.
- R10: Writes to index 2 change neither bank output nor irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_cyc_en | input | 1 | High for one clock per CPU cycle |
| wr_valid | input | 1 | A committed register value is present |
| wr_sel | input | 2 | Register index of the committed value |
| wr_data | input | 5 | Committed 5-bit register value |
| irq | output | 1 | Level interrupt request |
| bank_lo | output | 4 | 16 KB program bank for the 0x8000 window |
| bank_hi | output | 4 | 16 KB program bank for the 0xC000 window |

## Verification
Suppose the timer state or counter goes wrong, for example a missed clear or a count on a disabled cycle. That fault shows up on irq only at the threshold crossing, which may be thousands of enabled cycles later. The bench therefore checks the exact cycle of the edge, on both sides, after each clearing or resuming write. A wrong banking register shows on bank_lo or bank_hi in the cycle right after the offending write, so each vector is checked one clock after its last write.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;
    localparam int BANK_W = 4;
    localparam int VAL_W  = 5;

    typedef enum logic [1:0] {
        T_RUN  = 2'd0,
        T_PEND = 2'd1,
        T_HOLD = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/cyc_irq_regs.sv
module cyc_irq_regs
    import cyc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [1:0]       wr_sel,
    input  logic [VAL_W-1:0] wr_data,
    output logic [VAL_W-1:0] mode_q,
    output logic [VAL_W-1:0] tmr_q,
    output logic [VAL_W-1:0] prg_q,
    output logic             tmr_clr_wr,
    output logic             tmr_run_wr
);
    localparam logic [VAL_W-1:0] MODE_RST = 5'h1F;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RST;
            tmr_q  <= '0;
            prg_q  <= '0;
        end else if (wr_valid) begin
            unique case (wr_sel)
                2'd0: mode_q <= wr_data;
                2'd1: tmr_q  <= wr_data;
                2'd3: prg_q  <= wr_data;
                default: ;
            endcase
        end
    end

    assign tmr_clr_wr = wr_valid && (wr_sel == 2'd1) &&  wr_data[4];
    assign tmr_run_wr = wr_valid && (wr_sel == 2'd1) && !wr_data[4];
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
    import cyc_irq_pkg::*;
#(
    parameter int         CNT_W   = 30,
    parameter logic [3:0] DIP_SET = 4'hE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_en,
    input  logic clr_wr,
    input  logic run_wr,
    output logic irq
);
    localparam int SH = CNT_W - 5;
    localparam logic [CNT_W-1:0] THR    = {5'b11111, {SH{1'b0}}};
    localparam logic [CNT_W-1:0] DIP_SH = {1'b0, DIP_SET, {SH{1'b0}}};

    tmr_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
    logic             hit;

    assign cnt_inc = cnt_q + 1'b1;
    assign hit     = (cnt_inc | DIP_SH) >= THR;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (clr_wr) begin
            st_d  = T_HOLD;
            cnt_d = '0;
        end else if (run_wr && st_q == T_HOLD) begin
            st_d  = T_RUN;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                T_RUN, T_PEND: begin
                    if (cyc_en) begin
                        if (hit) begin
                            cnt_d = '0;
                            st_d  = T_PEND;
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end
                end
                T_HOLD: ;
                default: st_d = T_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= T_RUN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        irq = (st_q == T_PEND);
    end
endmodule

// File: rtl/cyc_irq_prg_map.sv
module cyc_irq_prg_map
    import cyc_irq_pkg::*;
(
    input  logic [VAL_W-1:0]  mode_q,
    input  logic [VAL_W-1:0]  tmr_q,
    input  logic [VAL_W-1:0]  prg_q,
    output logic [BANK_W-1:0] bank_lo,
    output logic [BANK_W-1:0] bank_hi
);
    logic [2:0] sel3;
    logic [2:0] pair;

    assign sel3 = prg_q[2:0];
    assign pair = {sel3[2:1], 1'b0};

    always_comb begin
        if (!tmr_q[3]) begin
            bank_lo = {1'b0, tmr_q[2:1], 1'b0};
            bank_hi = {1'b0, tmr_q[2:1], 1'b1};
        end else begin
            unique case (mode_q[3:2])
                2'b11: begin
                    bank_lo = {1'b1, sel3};
                    bank_hi = 4'hF;
                end
                2'b10: begin
                    bank_lo = 4'h8;
                    bank_hi = {1'b1, sel3};
                end
                default: begin
                    bank_lo = {1'b1, pair};
                    bank_hi = {1'b1, pair | 3'd1};
                end
            endcase
        end
    end
endmodule

// File: rtl/cyc_irq_mapper.sv
module cyc_irq_mapper
    import cyc_irq_pkg::*;
#(
    parameter int         CNT_W   = 30,
    parameter logic [3:0] DIP_SET = 4'hE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_cyc_en,
    input  logic        wr_valid,
    input  logic [1:0]  wr_sel,
    input  logic [4:0]  wr_data,
    output logic        irq,
    output logic [3:0]  bank_lo,
    output logic [3:0]  bank_hi
);
    logic [VAL_W-1:0] mode_q, tmr_q, prg_q;
    logic             clr_wr, run_wr;

    cyc_irq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel),
        .wr_data(wr_data), .mode_q(mode_q), .tmr_q(tmr_q), .prg_q(prg_q),
        .tmr_clr_wr(clr_wr), .tmr_run_wr(run_wr)
    );

    cyc_irq_timer #(.CNT_W(CNT_W), .DIP_SET(DIP_SET)) u_timer (
        .clk(clk), .rst_n(rst_n), .cyc_en(cpu_cyc_en),
        .clr_wr(clr_wr), .run_wr(run_wr), .irq(irq)
    );

    cyc_irq_prg_map u_map (
        .mode_q(mode_q), .tmr_q(tmr_q), .prg_q(prg_q),
        .bank_lo(bank_lo), .bank_hi(bank_hi)
    );
endmodule

// File: rtl/cyc_irq_mapper_chk.sv
module cyc_irq_mapper_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_cyc_en,
    input logic       wr_valid,
    input logic [1:0] wr_sel,
    input logic [4:0] wr_data,
    input logic       irq,
    input logic [3:0] bank_lo,
    input logic [3:0] bank_hi,
    input logic [4:0] tmr_q
);
    logic clr_now;
    assign clr_now = wr_valid && wr_sel == 2'd1 && wr_data[4];

    p_rise_needs_cyc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cpu_cyc_en));

    p_level_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_now) |=> irq);

    p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_now |=> !irq);

    p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q[4] |-> !irq);

    p_block_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_q[3] |-> (!bank_lo[0] && bank_hi == (bank_lo | 4'd1) && !bank_lo[3]));

    p_banks_need_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_valid) |-> ($stable(bank_lo) && $stable(bank_hi)));
endmodule

bind cyc_irq_mapper cyc_irq_mapper_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_cyc_en(cpu_cyc_en), .wr_valid(wr_valid),
    .wr_sel(wr_sel), .wr_data(wr_data), .irq(irq), .bank_lo(bank_lo),
    .bank_hi(bank_hi), .tmr_q(tmr_q)
);

// File: tb/test_cyc_irq_mapper.sv
module test_cyc_irq_mapper;
    localparam int CW = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_cyc_en = 1'b0;
    logic       wr_valid = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [4:0] wr_data = '0;
    logic       irq;
    logic [3:0] bank_lo, bank_hi;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cyc_irq_mapper #(.CNT_W(CW)) i_cyc_irq_mapper (
        .clk(clk), .rst_n(rst_n), .cpu_cyc_en(cpu_cyc_en), .wr_valid(wr_valid),
        .wr_sel(wr_sel), .wr_data(wr_data), .irq(irq),
        .bank_lo(bank_lo), .bank_hi(bank_hi)
    );

    // vector: mode, timer reg, program reg, expected lo, expected hi
    localparam int NV = 10;
    localparam logic [22:0] VEC [NV] = '{
        {5'h0C, 5'h00, 5'h00, 4'd0,  4'd1 },   // R2
        {5'h0C, 5'h06, 5'h00, 4'd6,  4'd7 },   // R2
        {5'h0C, 5'h02, 5'h00, 4'd2,  4'd3 },   // R2
        {5'h0C, 5'h08, 5'h05, 4'd13, 4'd15},   // R3
        {5'h0C, 5'h08, 5'h0F, 4'd15, 4'd15},   // R3
        {5'h08, 5'h08, 5'h03, 4'd8,  4'd11},   // R4
        {5'h00, 5'h08, 5'h05, 4'd12, 4'd13},   // R5
        {5'h04, 5'h08, 5'h0E, 4'd14, 4'd15},   // R5
        {5'h08, 5'h0A, 5'h07, 4'd8,  4'd15},   // R4
        {5'h00, 5'h04, 5'h07, 4'd4,  4'd5 }    // R2
    };

    function automatic int first_hit(int dip);
        int sh = CW - 5;
        for (int n = 1; n < (1 << CW); n++)
            if (((n | (dip << sh))) >= (31 << sh)) return n;
        return -1;
    endfunction

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] s, logic [4:0] d);
        wr_valid = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic run(int k);
        cpu_cyc_en = 1'b1;
        repeat (k) @(negedge clk);
        cpu_cyc_en = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int nhit;
        nhit = first_hit(14);
        repeat (3) @(negedge clk);
        check("R1 lo", bank_lo, 0); check("R1 hi", bank_hi, 1); check("R1 irq", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 lo after", bank_lo, 0); check("R1 hi after", bank_hi, 1);

        // R6: exact edge of first interrupt, disabled cycles do not count
        run(nhit - 1);
        repeat (50) @(negedge clk);
        check("R6 before", irq, 0);
        run(1);
        check("R6 at N", irq, 1);
        // R7: level stays through idle and enabled cycles
        repeat (20) @(negedge clk);
        check("R7 idle", irq, 1);
        run(nhit + 5);
        check("R7 running", irq, 1);
        // R8: clear and hold
        wr(2'd1, 5'h10);
        check("R8 cleared", irq, 0);
        run(3 * nhit);
        check("R8 held", irq, 0);
        // R9: resume from zero
        wr(2'd1, 5'h00);
        run(nhit - 1);
        check("R9 N-1", irq, 0);
        run(1);
        check("R9 N", irq, 1);
        wr(2'd1, 5'h00);
        check("R9 no clear", irq, 1);
        // R8: mid-count clear restarts counting
        wr(2'd1, 5'h10);
        wr(2'd1, 5'h00);
        run(nhit / 2);
        wr(2'd1, 5'h10);
        wr(2'd1, 5'h00);
        run(nhit - 1);
        check("R8 restart N-1", irq, 0);
        run(1);
        check("R8 restart N", irq, 1);
        wr(2'd1, 5'h10);

        // R1: reset mode register value, observed through banking
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        wr(2'd1, 5'h18);
        check("R1 mode lo", bank_lo, 8); check("R1 mode hi", bank_hi, 15);

        for (int i = 0; i < NV; i++) begin
            wr(2'd0, VEC[i][22:18]);
            wr(2'd1, VEC[i][17:13] | 5'h10);
            wr(2'd3, VEC[i][12:8]);
            check($sformatf("R2-5 vec%0d lo", i), bank_lo, int'(VEC[i][7:4]));
            check($sformatf("R2-5 vec%0d hi", i), bank_hi, int'(VEC[i][3:0]));
        end

        // R10: index 2 writes ignored
        wr(2'd2, 5'h1F);
        wr(2'd2, 5'h00);
        check("R10 lo", bank_lo, 4); check("R10 hi", bank_hi, 5); check("R10 irq", irq, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule